// File: doc/BRIEF.md
# Register Rename Mapping Tracker

This block holds, for every architectural register, the tag of the youngest in-flight instruction that writes it. A consumer presents a register ID on the lookup port and sees at once whether a producer is still in flight and, if so, its tag. When a writer is renamed, the allocate port records its tag against its destination register. When the writer retires, the release port returns its temporary register to the pool.

Alongside the table the block counts temporary rename registers. The pool size is a parameter, and a size of zero means the pool is unbounded. The availability query takes the number of register writes a dispatch group needs and answers whether the pool can cover them. Three counters report the temporaries held now, the largest number held since reset, and the number of mappings accepted since reset.

Top module: `rename_map_tracker`

## Requirements
- R1: After a synchronous active-low reset, every lookup misses (`lk_hit` = 0) and `used_cnt`, `peak_cnt` and `total_cnt` are zero.
- R2: An accepted allocate of register r with tag t makes a lookup of r, from the cycle after the clock edge, return `lk_hit` = 1 and `lk_tag` = t. A later allocate to r replaces the earlier tag, because only the youngest writer is kept.
- R3: A release with tag t invalidates every entry that still holds t, so a lookup of that register then misses.
- R4: A release whose tag is no longer held by the entry, because a newer writer replaced it, leaves that entry and its newer tag in place.
- R5: Each accepted allocate adds one to `used_cnt`, and each release subtracts one. A release while `used_cnt` is zero and no allocate is accepted changes nothing.
- R6: With a nonzero limit, an allocate while `used_cnt` equals the limit and no release comes in the same cycle is refused. The table and all counters are left unchanged.
- R7: An allocate and a release in the same cycle change `used_cnt` by their net effect (zero) and are accepted even when the pool is full. If both touch the same register, the new allocate's tag wins.
- R8: `peak_cnt` equals the largest value `used_cnt` has held since reset. It is compared against the value after each update.
- R9: `total_cnt` counts the allocates accepted since reset. Refused allocates are not counted.
- R10: With a nonzero limit L, `can_rename` is 1 exactly when `need_cnt` ≤ L − `used_cnt`.
- R11: With a limit of zero, `can_rename` is always 1 and no allocate is refused, so `used_cnt` can grow past any fixed pool size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Request to rename one write |
| alloc_reg | input | REG_W | Destination architectural register of the write |
| alloc_tag | input | TAG_W | Tag of the writing instruction |
| rel_valid | input | 1 | Request to free one writer's temporary |
| rel_tag | input | TAG_W | Tag of the writer being freed |
| lk_reg | input | REG_W | Register being looked up |
| lk_hit | output | 1 | An in-flight writer of `lk_reg` exists |
| lk_tag | output | TAG_W | Tag of that writer (valid with `lk_hit`) |
| need_cnt | input | NEED_W | Number of writes the availability query asks about |
| can_rename | output | 1 | Enough temporaries are free for `need_cnt` writes |
| used_cnt | output | CNT_W | Temporaries held now |
| peak_cnt | output | CNT_W | Highest `used_cnt` since reset |
| total_cnt | output | CNT_W | Allocates accepted since reset |

## Verification
A single writer per register, followed by its release, shows basic recording and clearing. Two writers of the same register, released oldest first, tell a match-guarded clear apart from a clear by register. Driving allocates past a four-entry limit tells a refused allocate from an accepted one, and a second, unlimited instance given the same stimulus shows that a zero limit removes refusal. Paired allocate and release cycles, including one on a full pool and one on the same register, check the net counter update and which write wins the table entry.

// File: rtl/rmt_pkg.sv
// Package: shared helpers for the rename mapping tracker.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package rmt_pkg;

    // Width needed to index n items, never less than one bit.
    function automatic int unsigned id_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rmt_table.sv
// Module: rmt_table
// Holds one entry per architectural register: a valid flag and the tag of
// the youngest writer. A write sets the entry. A clear invalidates every
// entry whose stored tag equals the clear tag, and a write to the same entry
// in that cycle wins. Lookup is combinational.
// Assumes: tags are unique among in-flight writers; writes cover the whole
// register.
module rmt_table #(
    parameter int NUM_REGS = 16,
    parameter int REG_W    = 4,
    parameter int TAG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [REG_W-1:0] lk_reg,
    output logic             lk_hit,
    output logic [TAG_W-1:0] lk_tag
);

    logic [NUM_REGS-1:0] vld_q;
    logic [TAG_W-1:0]    tag_q [NUM_REGS];

    // Update entries: a write sets its entry, a matching clear drops others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                tag_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_en && (wr_reg == REG_W'(i))) begin
                    vld_q[i] <= 1'b1;
                    tag_q[i] <= wr_tag;
                end else if (clr_en && vld_q[i] && (tag_q[i] == clr_tag)) begin
                    vld_q[i] <= 1'b0;
                end
            end
        end
    end

    // Combinational read of the addressed entry, guarded against bad IDs.
    always_comb begin
        lk_hit = 1'b0;
        lk_tag = '0;
        if (int'(lk_reg) < NUM_REGS) begin
            lk_hit = vld_q[lk_reg];
            lk_tag = tag_q[lk_reg];
        end
    end

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_reg)] && (tag_q[$past(wr_reg)] == $past(wr_tag)))); // R2

    AST_IDLE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> $stable(vld_q)); // R6

    AST_CLEAR_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> ($countones(vld_q) <= $countones($past(vld_q)))); // R3

endmodule

// File: rtl/rmt_count.sv
// Module: rmt_count
// Accounts for temporary rename registers. It decides which allocate and
// release requests are accepted, keeps the in-use, peak and lifetime
// counters, and answers the availability query. A limit of zero builds
// the unbounded variant.
// Assumes: the counters are wide enough for the run length; a release always
// names a writer that holds a temporary.
module rmt_count #(
    parameter int MAX_TEMPS = 4,
    parameter int CNT_W     = 12,
    parameter int NEED_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    input  logic              rel_req,
    input  logic [NEED_W-1:0] need,
    output logic              alloc_acc,
    output logic              rel_acc,
    output logic              avail_ok,
    output logic [CNT_W-1:0]  used,
    output logic [CNT_W-1:0]  peak,
    output logic [CNT_W-1:0]  total
);

    localparam bit               UNLIM = (MAX_TEMPS == 0);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_TEMPS);

    logic             room;
    logic [CNT_W-1:0] used_nx;

    // Accept decisions: a full pool still takes an allocate paired with a release.
    always_comb begin
        room      = UNLIM || (used < LIMIT);
        alloc_acc = alloc_req && (room || (rel_req && (used != '0)));
        rel_acc   = rel_req && ((used != '0) || alloc_acc);
        used_nx   = used + CNT_W'(alloc_acc) - CNT_W'(rel_acc);
    end

    // Counter registers: net in-use change, peak against post-update value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used  <= '0;
            peak  <= '0;
            total <= '0;
        end else begin
            used <= used_nx;
            if (used_nx > peak) begin
                peak <= used_nx;
            end
            if (alloc_acc) begin
                total <= total + 1'b1;
            end
        end
    end

    generate
        if (UNLIM) begin : g_unbounded
            // Unbounded pool: every query succeeds.
            assign avail_ok = 1'b1;
        end else begin : g_bounded
            // Bounded pool: compare the request with the free temporaries.
            assign avail_ok = (CNT_W'(need) <= (LIMIT - used));

            AST_USE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                used <= LIMIT); // R6
        end
    endgenerate

    AST_PEAK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        peak >= used); // R8

    AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_acc |=> (total == $past(total) + 1'b1)); // R9

    AST_NET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_acc && rel_acc) |=> $stable(used)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_req && !rel_req) |=> ($stable(used) && $stable(total))); // R5

endmodule

// File: rtl/rename_map_tracker.sv
// Module: rename_map_tracker
// Top level: ties the per-register writer table to the temporary-register
// accounting. Only accepted requests reach the table, so a refused allocate
// leaves no trace.
// Assumes: one allocate and one release at most per cycle.
module rename_map_tracker #(
    parameter int NUM_REGS  = 16,
    parameter int TAG_W     = 5,
    parameter int MAX_TEMPS = 4,
    parameter int NEED_W    = 4,
    parameter int CNT_W     = 12,
    localparam int REG_W    = rmt_pkg::id_bits(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [REG_W-1:0]  alloc_reg,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              rel_valid,
    input  logic [TAG_W-1:0]  rel_tag,
    input  logic [REG_W-1:0]  lk_reg,
    output logic              lk_hit,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic [NEED_W-1:0] need_cnt,
    output logic              can_rename,
    output logic [CNT_W-1:0]  used_cnt,
    output logic [CNT_W-1:0]  peak_cnt,
    output logic [CNT_W-1:0]  total_cnt
);

    logic alloc_acc;
    logic rel_acc;

    rmt_count #(
        .MAX_TEMPS (MAX_TEMPS),
        .CNT_W     (CNT_W),
        .NEED_W    (NEED_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_req (alloc_valid),
        .rel_req   (rel_valid),
        .need      (need_cnt),
        .alloc_acc (alloc_acc),
        .rel_acc   (rel_acc),
        .avail_ok  (can_rename),
        .used      (used_cnt),
        .peak      (peak_cnt),
        .total     (total_cnt)
    );

    rmt_table #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .TAG_W    (TAG_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_acc),
        .wr_reg  (alloc_reg),
        .wr_tag  (alloc_tag),
        .clr_en  (rel_acc),
        .clr_tag (rel_tag),
        .lk_reg  (lk_reg),
        .lk_hit  (lk_hit),
        .lk_tag  (lk_tag)
    );

    AST_REFUSE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ((MAX_TEMPS != 0) && alloc_valid && !rel_valid
         && (used_cnt == CNT_W'(MAX_TEMPS)))
        |=> ($stable(used_cnt) && $stable(total_cnt))); // R6

endmodule

// File: tb/rename_map_tracker_bench.sv
// Bench: directed scenarios, one task each, every task checking its results.
// A second instance with an unbounded pool shares the stimulus.
module rename_map_tracker_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [3:0]  alloc_reg = '0;
    logic [4:0]  alloc_tag = '0;
    logic        rel_valid = 1'b0;
    logic [4:0]  rel_tag = '0;
    logic [3:0]  lk_reg = '0;
    logic [3:0]  need_cnt = '0;
    logic        lk_hit, nl_hit;
    logic [4:0]  lk_tag, nl_tag;
    logic        can_rename, nl_can;
    logic [11:0] used_cnt, peak_cnt, total_cnt;
    logic [11:0] nl_used, nl_peak, nl_total;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rename_map_tracker u_rename_map_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_tag(lk_tag),
        .need_cnt(need_cnt), .can_rename(can_rename),
        .used_cnt(used_cnt), .peak_cnt(peak_cnt), .total_cnt(total_cnt)
    );

    rename_map_tracker #(.MAX_TEMPS(0)) u_nolimit (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .lk_reg(lk_reg), .lk_hit(nl_hit), .lk_tag(nl_tag),
        .need_cnt(need_cnt), .can_rename(nl_can),
        .used_cnt(nl_used), .peak_cnt(nl_peak), .total_cnt(nl_total)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock with the given requests; returns just after the edge.
    task automatic step(input logic av, input logic [3:0] r, input logic [4:0] t,
                        input logic rv, input logic [4:0] rt);
        @(negedge clk);
        alloc_valid = av; alloc_reg = r; alloc_tag = t;
        rel_valid = rv; rel_tag = rt;
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic look(input logic [3:0] r);
        lk_reg = r;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        look(4'd0);  chk("R1 hit r0", lk_hit, 0);
        look(4'd9);  chk("R1 hit r9", lk_hit, 0);
        look(4'd15); chk("R1 hit r15", lk_hit, 0);
        chk("R1 used", used_cnt, 0);
        chk("R1 peak", peak_cnt, 0);
        chk("R1 total", total_cnt, 0);
        need_cnt = 4'd4; #1; chk("R10 need4 empty", can_rename, 1);
        need_cnt = 4'd5; #1; chk("R10 need5 empty", can_rename, 0);
    endtask

    task automatic t_basic();
        do_reset();
        step(1, 4'd3, 5'd7, 0, 5'd0);
        look(4'd3); chk("R2 hit", lk_hit, 1); chk("R2 tag", lk_tag, 7);
        chk("R5 used after alloc", used_cnt, 1);
        step(1, 4'd3, 5'd9, 0, 5'd0);
        look(4'd3); chk("R2 override tag", lk_tag, 9);
        chk("R5 used two", used_cnt, 2);
        step(0, 4'd0, 5'd0, 1, 5'd7);
        look(4'd3); chk("R4 newer kept hit", lk_hit, 1); chk("R4 newer tag", lk_tag, 9);
        chk("R5 used after release", used_cnt, 1);
        step(0, 4'd0, 5'd0, 1, 5'd9);
        look(4'd3); chk("R3 cleared", lk_hit, 0);
        chk("R5 used zero", used_cnt, 0);
        chk("R8 peak", peak_cnt, 2);
        chk("R9 total", total_cnt, 2);
        step(0, 4'd0, 5'd0, 1, 5'd5);
        chk("R5 release at zero", used_cnt, 0);
        chk("R5 total unchanged", total_cnt, 2);
    endtask

    task automatic t_limit();
        do_reset();
        for (int i = 0; i < 4; i++) begin
            step(1, 4'(i), 5'(i + 1), 0, 5'd0);
        end
        chk("R6 used full", used_cnt, 4);
        need_cnt = 4'd1; #1; chk("R10 full need1", can_rename, 0);
        need_cnt = 4'd0; #1; chk("R10 full need0", can_rename, 1);
        step(1, 4'd4, 5'd5, 0, 5'd0);
        step(1, 4'd5, 5'd6, 0, 5'd0);
        look(4'd4); chk("R6 refused r4", lk_hit, 0);
        look(4'd5); chk("R6 refused r5", lk_hit, 0);
        chk("R6 used held", used_cnt, 4);
        chk("R9 total excludes refused", total_cnt, 4);
        chk("R11 nolimit used", nl_used, 6);
        chk("R11 nolimit total", nl_total, 6);
        look(4'd5); chk("R11 nolimit r5 hit", nl_hit, 1); chk("R11 nolimit r5 tag", nl_tag, 6);
        need_cnt = 4'd15; #1; chk("R11 nolimit avail", nl_can, 1);
        step(0, 4'd0, 5'd0, 1, 5'd1);
        need_cnt = 4'd1; #1; chk("R10 one free need1", can_rename, 1);
        need_cnt = 4'd2; #1; chk("R10 one free need2", can_rename, 0);
    endtask

    task automatic t_same();
        do_reset();
        step(1, 4'd1, 5'd1, 0, 5'd0);
        step(1, 4'd2, 5'd2, 0, 5'd0);
        step(1, 4'd1, 5'd3, 1, 5'd1);
        look(4'd1); chk("R7 alloc wins hit", lk_hit, 1); chk("R7 alloc wins tag", lk_tag, 3);
        chk("R7 net used", used_cnt, 2);
        chk("R8 peak post-update", peak_cnt, 2);
        chk("R9 total three", total_cnt, 3);
        step(1, 4'd5, 5'd4, 0, 5'd0);
        step(1, 4'd6, 5'd5, 0, 5'd0);
        chk("R5 used four", used_cnt, 4);
        step(1, 4'd7, 5'd6, 1, 5'd2);
        look(4'd7); chk("R7 full pair accepted", lk_hit, 1); chk("R7 full pair tag", lk_tag, 6);
        look(4'd2); chk("R3 paired release clears", lk_hit, 0);
        chk("R7 used stays full", used_cnt, 4);
        chk("R9 total six", total_cnt, 6);
        chk("R8 peak four", peak_cnt, 4);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_limit();
        t_same();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule